// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the general-purpose register storage of a 32-bit RISC core. It keeps several complete copies of the register set. Set 0 is the normal set, and sets 1 to `NUM_SHADOW` are shadow sets that an interrupt handler can use as its own context. A shadow set behaves exactly like the normal set. The only thing that tells the sets apart is the 6-bit current-set selector `cur_set`, which comes from an external status register along with the 6-bit previous-set selector `prv_set`.

Ordinary traffic uses the set named by `cur_set`:

- two combinational read ports, A and B;
- one synchronous write port;
- a dedicated link write that loads the return-address register, index 31.

In supervisor mode, software can also reach a different set, the one named by `prv_set`. It does this by marking read port B or the write port as cross-set. A cross-set attempt outside supervisor mode is suppressed and reported. A selector that names a set that does not exist is also suppressed and reported.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register of every set reads as zero, and both `illegal_access` and `range_err` are low.
- R2: Register index 0 reads as zero in every set on both read ports. A write to index 0 is discarded.
- R3: When `wr_en` is high and `wr_cross` is low, `wr_data` is stored at `wr_idx` of set `cur_set` at the clock edge. From the next cycle it reads back on port A, and on port B when `rd_b_cross` is low.
- R4: When `link_we` is high, `link_data` is stored in index 31 of set `cur_set`. Any general write requested in the same cycle is discarded.
- R5: A write to one set leaves the same index in every other set unchanged.
- R6: When `rd_b_cross` and `supervisor` are both high, port B reads index `rd_b_idx` of set `prv_set`. Port A keeps reading set `cur_set`.
- R7: When `wr_en`, `wr_cross` and `supervisor` are all high, the write goes to set `prv_set`.
- R8: A cross-set attempt while `supervisor` is low is suppressed. A cross-set attempt means `rd_b_cross` high, or `wr_en` and `wr_cross` both high. When it is suppressed, the write is discarded and port B reads zero. `illegal_access` is then high in the cycle after each such attempt cycle, and low after a cycle with no attempt.
- R9: A selector above `NUM_SHADOW` is out of range (`NUM_SHADOW` = 3 by default). The selector is `cur_set` for ordinary accesses, or `prv_set` for a permitted cross-set access. Writes through an out-of-range selector are ignored and reads through it return zero. `range_err` is high in the cycle after any cycle in which the selector in use was out of range.
- R10: There is no write-through bypass. A read of the register being written in the same cycle returns the old value, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all sets and flags |
| cur_set | input | 6 | Current register set selector |
| prv_set | input | 6 | Set selector used by cross-set accesses |
| supervisor | input | 1 | High when the core is in supervisor mode |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_cross | input | 1 | Port B reads set `prv_set` instead of `cur_set` |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | General write request |
| wr_cross | input | 1 | The general write targets set `prv_set` |
| wr_idx | input | 5 | General write register index |
| wr_data | input | 32 | General write data |
| link_we | input | 1 | Write the return address into index 31 of set `cur_set` |
| link_data | input | 32 | Return-address value |
| illegal_access | output | 1 | Registered flag: a cross-set attempt was made outside supervisor mode |
| range_err | output | 1 | Registered flag: an access used a set selector above `NUM_SHADOW` |

## Verification
A wrong internal state shows up only when that register is next read. A misdirected write shows on one of the data ports in the cycle after the write edge, but only once the bench points a port at the corrupted set and index. A write that lands in the wrong set therefore needs a read of both the intended set and a neighbouring set to expose it. A bad error flag shows exactly one cycle after the offending access, because both flags are single registers. Read data is combinational from storage, so any bypass or select fault shows within the same cycle that the selectors change.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int RF_SEL_W     = 6;
   localparam int RF_MAX_SHADOW = 63;

   typedef enum logic [1:0] {
      WSRC_NONE  = 2'd0,
      WSRC_LINK  = 2'd1,
      WSRC_NORM  = 2'd2,
      WSRC_CROSS = 2'd3
   } wsrc_e;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && (widx != '0)) begin
         mem[widx] <= wdata;
      end
   end

   assign ra_data = (ra_idx == '0) ? '0 : mem[ra_idx];
   assign rb_data = (rb_idx == '0) ? '0 : mem[rb_idx];

   // R3: an accepted write is held in storage after the edge
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (widx != '0)) |=> (mem[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/rf_access_ctl.sv
module rf_access_ctl
   import rf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 5,
   parameter int SEL_W      = RF_SEL_W,
   parameter int NUM_SHADOW = 3,
   localparam int NSETS     = NUM_SHADOW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  cur_set,
   input  logic [SEL_W-1:0]  prv_set,
   input  logic              supervisor,
   input  logic              rd_b_cross,
   input  logic              wr_en,
   input  logic              wr_cross,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              link_we,
   input  logic [DATA_W-1:0] link_data,
   output logic [NSETS-1:0]  bank_we,
   output logic [IDX_W-1:0]  w_idx,
   output logic [DATA_W-1:0] w_data,
   output logic [SEL_W-1:0]  b_sel,
   output logic              b_kill,
   output logic              illegal_q,
   output logic              range_q
);
   localparam logic [IDX_W-1:0] LINK_IDX = {IDX_W{1'b1}};
   localparam logic [SEL_W-1:0] TOP_SET  = SEL_W'(NUM_SHADOW);

   wsrc_e            wsrc;
   logic [SEL_W-1:0] w_set;
   logic             cross_try, cross_ok, cur_oor, prv_oor;

   assign cross_try = rd_b_cross | (wr_en & wr_cross);
   assign cross_ok  = cross_try & supervisor;
   assign cur_oor   = cur_set > TOP_SET;
   assign prv_oor   = prv_set > TOP_SET;

   always_comb begin
      if (link_we)                      wsrc = WSRC_LINK;
      else if (wr_en && !wr_cross)      wsrc = WSRC_NORM;
      else if (wr_en && supervisor)     wsrc = WSRC_CROSS;
      else                              wsrc = WSRC_NONE;
   end

   always_comb begin
      w_set  = cur_set;
      w_idx  = wr_idx;
      w_data = wr_data;
      unique case (wsrc)
         WSRC_LINK:  begin w_idx = LINK_IDX; w_data = link_data; end
         WSRC_CROSS: w_set = prv_set;
         default:    ;
      endcase
   end

   for (genvar s = 0; s < NSETS; s++) begin : g_we
      assign bank_we[s] = (wsrc != WSRC_NONE) && (w_set == SEL_W'(s));
   end

   assign b_sel  = rd_b_cross ? prv_set : cur_set;
   assign b_kill = rd_b_cross & ~supervisor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         illegal_q <= 1'b0;
         range_q   <= 1'b0;
      end else begin
         illegal_q <= cross_try & ~supervisor;
         range_q   <= cur_oor | (cross_ok & prv_oor);
      end
   end

   // R9: at most one bank is written per cycle, none when out of range
   a_r9_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));
   // R8: a blocked cross write reaches no bank
   a_r8_no_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cross && !supervisor && !link_we) |-> (bank_we == '0));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import rf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 5,
   parameter int SEL_W      = RF_SEL_W,
   parameter int NUM_SHADOW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  cur_set,
   input  logic [SEL_W-1:0]  prv_set,
   input  logic              supervisor,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   input  logic              rd_b_cross,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic              wr_cross,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              link_we,
   input  logic [DATA_W-1:0] link_data,
   output logic              illegal_access,
   output logic              range_err
);
   localparam int NSETS = NUM_SHADOW + 1;
   localparam logic [SEL_W-1:0] TOP_SET = SEL_W'(NUM_SHADOW);

   initial begin
      assert (NUM_SHADOW >= 0 && NUM_SHADOW <= RF_MAX_SHADOW)
         else $error("NUM_SHADOW out of supported range");
      assert (NUM_SHADOW < (1 << SEL_W))
         else $error("SEL_W too narrow for NUM_SHADOW");
      assert (DATA_W > 0 && IDX_W > 0)
         else $error("bad width parameter");
   end

   logic [NSETS-1:0]  bank_we;
   logic [IDX_W-1:0]  w_idx;
   logic [DATA_W-1:0] w_data;
   logic [SEL_W-1:0]  b_sel;
   logic              b_kill;
   logic [DATA_W-1:0] ra_all [NSETS];
   logic [DATA_W-1:0] rb_all [NSETS];

   rf_access_ctl #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .NUM_SHADOW(NUM_SHADOW)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .cur_set(cur_set), .prv_set(prv_set),
      .supervisor(supervisor), .rd_b_cross(rd_b_cross), .wr_en(wr_en),
      .wr_cross(wr_cross), .wr_idx(wr_idx), .wr_data(wr_data),
      .link_we(link_we), .link_data(link_data), .bank_we(bank_we),
      .w_idx(w_idx), .w_data(w_data), .b_sel(b_sel), .b_kill(b_kill),
      .illegal_q(illegal_access), .range_q(range_err)
   );

   for (genvar s = 0; s < NSETS; s++) begin : g_set
      rf_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .we(bank_we[s]), .widx(w_idx),
         .wdata(w_data), .ra_idx(rd_a_idx), .ra_data(ra_all[s]),
         .rb_idx(rd_b_idx), .rb_data(rb_all[s])
      );
   end

   always_comb begin
      rd_a_data = '0;
      rd_b_data = '0;
      for (int s = 0; s < NSETS; s++) begin
         if (cur_set == SEL_W'(s)) rd_a_data |= ra_all[s];
         if (!b_kill && (b_sel == SEL_W'(s))) rd_b_data |= rb_all[s];
      end
   end

   // R2: index zero reads zero on both ports
   a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_a_idx == '0) |-> (rd_a_data == '0)) and
      ((rd_b_idx == '0) |-> (rd_b_data == '0)));
   // R8: blocked cross read returns zero and raises the flag next cycle
   a_r8_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_cross && !supervisor) |-> (rd_b_data == '0));
   a_r8_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_cross && !supervisor) |=> illegal_access);
   // R9: out-of-range current set reads zero and flags next cycle
   a_r9_oor_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_set > TOP_SET) |-> (rd_a_data == '0));
   a_r9_oor_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_set > TOP_SET) |=> range_err);
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cur_set = '0, prv_set = '0;
   logic        supervisor = 1'b0;
   logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic        rd_b_cross = 1'b0, wr_en = 1'b0, wr_cross = 1'b0, link_we = 1'b0;
   logic [31:0] wr_data = '0, link_data = '0;
   logic [31:0] rd_a_data, rd_b_data;
   logic        illegal_access, range_err;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_regfile u0 (
      .clk(clk), .rst_n(rst_n), .cur_set(cur_set), .prv_set(prv_set),
      .supervisor(supervisor), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_cross(rd_b_cross), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_cross(wr_cross), .wr_idx(wr_idx), .wr_data(wr_data),
      .link_we(link_we), .link_data(link_data),
      .illegal_access(illegal_access), .range_err(range_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle();
      wr_en = 0; wr_cross = 0; link_we = 0; rd_b_cross = 0;
   endtask

   // Drive at a negedge, let one posedge pass, return at the next negedge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] set, input logic [4:0] idx, input logic [31:0] d);
      cur_set = set; wr_en = 1; wr_idx = idx; wr_data = d;
      step();
      idle();
   endtask

   task automatic rd_a(input string tag, input logic [5:0] set, input logic [4:0] idx,
                       input logic [31:0] exp);
      cur_set = set; rd_a_idx = idx;
      #1;
      chk(tag, rd_a_data, exp);
   endtask

   task automatic t_reset();
      rd_a("R1 set0 r5", 6'd0, 5'd5, 32'h0);
      rd_a("R1 set3 r31", 6'd3, 5'd31, 32'h0);
      chk("R1 illegal_access", {31'b0, illegal_access}, 32'h0);
      chk("R1 range_err", {31'b0, range_err}, 32'h0);
      cur_set = 0;
   endtask

   task automatic t_zero();
      wr(6'd0, 5'd0, 32'hDEAD_BEEF);
      rd_a("R2 r0 port A", 6'd0, 5'd0, 32'h0);
      rd_b_idx = 0; #1;
      chk("R2 r0 port B", rd_b_data, 32'h0);
   endtask

   task automatic t_basic();
      wr(6'd0, 5'd5, 32'hAAAA_0005);
      wr(6'd0, 5'd6, 32'hBBBB_0006);
      rd_a("R3 set0 r5 port A", 6'd0, 5'd5, 32'hAAAA_0005);
      rd_b_idx = 6; #1;
      chk("R3 set0 r6 port B", rd_b_data, 32'hBBBB_0006);
   endtask

   task automatic t_link();
      cur_set = 1; wr_en = 1; wr_idx = 7; wr_data = 32'h7777_7777;
      link_we = 1; link_data = 32'h0000_1234;
      step(); idle();
      rd_a("R4 link into r31", 6'd1, 5'd31, 32'h0000_1234);
      rd_a("R4 general write discarded", 6'd1, 5'd7, 32'h0);
   endtask

   task automatic t_indep();
      wr(6'd2, 5'd5, 32'hCCCC_0005);
      rd_a("R5 set2 r5", 6'd2, 5'd5, 32'hCCCC_0005);
      rd_a("R5 set0 r5 untouched", 6'd0, 5'd5, 32'hAAAA_0005);
      rd_a("R5 set1 r5 untouched", 6'd1, 5'd5, 32'h0);
   endtask

   task automatic t_cross_rd();
      supervisor = 1; cur_set = 0; prv_set = 2; rd_b_cross = 1;
      rd_b_idx = 5; rd_a_idx = 5; #1;
      chk("R6 cross read port B", rd_b_data, 32'hCCCC_0005);
      chk("R6 port A stays current", rd_a_data, 32'hAAAA_0005);
      step(); idle();
      chk("R6 no illegal flag", {31'b0, illegal_access}, 32'h0);
   endtask

   task automatic t_cross_wr();
      supervisor = 1; cur_set = 0; prv_set = 3;
      wr_en = 1; wr_cross = 1; wr_idx = 9; wr_data = 32'hDDDD_0009;
      step(); idle();
      rd_a("R7 set3 r9 written", 6'd3, 5'd9, 32'hDDDD_0009);
      rd_a("R7 set0 r9 untouched", 6'd0, 5'd9, 32'h0);
   endtask

   task automatic t_illegal();
      supervisor = 0; cur_set = 0; prv_set = 3;
      wr_en = 1; wr_cross = 1; wr_idx = 9; wr_data = 32'hEEEE_0009;
      step(); idle();
      chk("R8 illegal flag after write", {31'b0, illegal_access}, 32'h1);
      step();
      chk("R8 illegal flag one cycle", {31'b0, illegal_access}, 32'h0);
      rd_a("R8 blocked write discarded", 6'd3, 5'd9, 32'hDDDD_0009);
      cur_set = 0; prv_set = 2; rd_b_cross = 1; rd_b_idx = 5; #1;
      chk("R8 blocked read zero", rd_b_data, 32'h0);
      step(); idle();
      chk("R8 illegal flag after read", {31'b0, illegal_access}, 32'h1);
      supervisor = 1;
   endtask

   task automatic t_range();
      step();
      rd_a("R9 out of range read zero", 6'd5, 5'd5, 32'h0);
      wr(6'd5, 5'd5, 32'hFFFF_0005);
      chk("R9 range flag", {31'b0, range_err}, 32'h1);
      cur_set = 0; step();
      chk("R9 range flag clears", {31'b0, range_err}, 32'h0);
      for (int s = 0; s < 4; s++) begin
         cur_set = 6'(s); rd_a_idx = 5; #1;
         chk("R9 no bank took write", rd_a_data,
             (s == 0) ? 32'hAAAA_0005 : (s == 2) ? 32'hCCCC_0005 : 32'h0);
      end
      cur_set = 0; supervisor = 1; prv_set = 7; rd_b_cross = 1; rd_b_idx = 5; #1;
      chk("R9 cross read out of range zero", rd_b_data, 32'h0);
      step(); idle();
      chk("R9 cross range flag", {31'b0, range_err}, 32'h1);
   endtask

   task automatic t_nobypass();
      cur_set = 0; rd_a_idx = 5;
      wr_en = 1; wr_idx = 5; wr_data = 32'h1357_9BDF; #1;
      chk("R10 old value same cycle", rd_a_data, 32'hAAAA_0005);
      step(); idle(); #1;
      chk("R10 new value next cycle", rd_a_data, 32'h1357_9BDF);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_zero();
      t_basic();
      t_link();
      t_indep();
      t_cross_rd();
      t_cross_wr();
      t_illegal();
      t_range();
      t_nobypass();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule